// File: doc/BRIEF.md
# Powered Door Handshake Controller

This block sequences a powered passenger door. An operator asks for the door to open or to close by raising a request line. The controller then runs the matching motor command until the position sensor for that end of travel reports arrival. Only then does it raise the matching done line. The done line stays high until the operator lowers the request, which closes a four-phase handshake. How long a handshake takes depends on the door's physical travel and not on any fixed latency.

An obstacle sensor guards the closing stroke. An obstacle seen while the door closes sends it back to the open end. The close request stays pending, and the door starts closing again once it is open and the obstacle has cleared. A request for the end the door already holds is answered at once, without running either motor. Every output is decoded from the state register alone. An input change therefore shows at the outputs one clock edge later.

The states are: SHUT (at rest, closed), OPENING (open motor on), OPEN_DONE (open done raised), OPENED (at rest, open), CLOSING (close motor on) and SHUT_DONE (close done raised). The transitions are as follows. SHUT goes to OPENING on an open request, or to SHUT_DONE on a close request alone. OPENING goes to OPEN_DONE when the open sensor is seen with an open request present, or to OPENED when it is seen without one. OPEN_DONE goes to OPENED when the open request falls. OPENED goes to OPEN_DONE on an open request, or to CLOSING on a close request while no obstacle is reported. CLOSING goes to OPENING on an obstacle or an open request, or to SHUT_DONE when the closed sensor is seen. SHUT_DONE goes to SHUT when the close request falls.

Top module: `door_ctl`

## Requirements
- R1: While reset (rst_n low) is asserted and after it is released, the controller is in SHUT and motor_open, motor_close, open_done and close_done are all low.
- R2: An open request in SHUT raises motor_open in the cycle after it is sampled. motor_open stays high until pos_open is sampled, and then open_done rises in place of motor_open.
- R3: open_done stays high while open_rq stays high and falls in the cycle after open_rq is sampled low.
- R4: A close request in OPENED, with no obstacle reported, raises motor_close until pos_shut is sampled. Then close_done rises and stays high until close_rq is sampled low, and it falls in the cycle after that.
- R5: An obstacle sampled while motor_close is high turns motor_close off and motor_open on in the next cycle. With close_rq still held, closing resumes after pos_open is seen and the obstacle has cleared.
- R6: In OPENED, a close request has no effect while obstacle is high: all four outputs stay low.
- R7: A close request in SHUT raises close_done in the next cycle, and an open request in OPENED raises open_done in the next cycle, with both motor outputs held low.
- R8: motor_open and motor_close are never high together, and neither motor output is high while open_done or close_done is high.
- R9: When open_rq and close_rq are both high in SHUT or in CLOSING, the open request wins: motor_open rises in the next cycle.
- R10: While the door is opening, obstacle has no effect: motor_open stays high until pos_open is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| open_rq | input | 1 | Operator open request |
| close_rq | input | 1 | Operator close request |
| pos_open | input | 1 | Sensor: door fully open |
| pos_shut | input | 1 | Sensor: door fully closed |
| obstacle | input | 1 | Sensor: obstacle in the doorway |
| motor_open | output | 1 | Drive the door toward open |
| motor_close | output | 1 | Drive the door toward closed |
| open_done | output | 1 | Open handshake acknowledge |
| close_done | output | 1 | Close handshake acknowledge |

## Verification
All four outputs are decoded from the state alone. A wrong state therefore shows at the ports in the same cycle it is entered. It appears as a motor running in a rest state, a missing or early done line, or both motors high together.

The sensor-gated transitions need specific checks. A done line that rises without a preceding sensor sample, or an obstacle that fails to reverse a closing stroke, is caught at the ports one edge after the input that should have caused the change. A missed acknowledge drop is caught the cycle after the request falls.

// File: rtl/door_ctl_pkg.sv
package door_ctl_pkg;

    typedef enum logic [2:0] {
        ST_SHUT      = 3'd0,
        ST_OPENING   = 3'd1,
        ST_OPEN_DONE = 3'd2,
        ST_OPENED    = 3'd3,
        ST_CLOSING   = 3'd4,
        ST_SHUT_DONE = 3'd5
    } door_state_e;

    typedef struct packed {
        logic open_rq;
        logic close_rq;
        logic pos_open;
        logic pos_shut;
        logic obstacle;
    } door_in_t;

    typedef struct packed {
        logic motor_open;
        logic motor_close;
        logic open_done;
        logic close_done;
    } door_out_t;

endpackage

// File: rtl/door_ctl_next.sv
module door_ctl_next
    import door_ctl_pkg::*;
(
    input  door_state_e cur_state,
    input  door_in_t    in_s,
    output door_state_e nxt_state
);

    always_comb begin
        nxt_state = cur_state;
        unique case (cur_state)
            ST_SHUT: begin
                if (in_s.open_rq)
                    nxt_state = ST_OPENING;
                else if (in_s.close_rq)
                    nxt_state = ST_SHUT_DONE;
            end
            ST_OPENING: begin
                if (in_s.pos_open)
                    nxt_state = in_s.open_rq ? ST_OPEN_DONE : ST_OPENED;
            end
            ST_OPEN_DONE: begin
                if (!in_s.open_rq)
                    nxt_state = ST_OPENED;
            end
            ST_OPENED: begin
                if (in_s.open_rq)
                    nxt_state = ST_OPEN_DONE;
                else if (in_s.close_rq && !in_s.obstacle)
                    nxt_state = ST_CLOSING;
            end
            ST_CLOSING: begin
                if (in_s.obstacle || in_s.open_rq)
                    nxt_state = ST_OPENING;
                else if (in_s.pos_shut)
                    nxt_state = ST_SHUT_DONE;
            end
            ST_SHUT_DONE: begin
                if (!in_s.close_rq)
                    nxt_state = ST_SHUT;
            end
            default: nxt_state = ST_SHUT;
        endcase
    end

endmodule

// File: rtl/door_ctl_outdec.sv
module door_ctl_outdec
    import door_ctl_pkg::*;
(
    input  door_state_e cur_state,
    output door_out_t   out_s
);

    always_comb begin
        out_s = '0;
        unique case (cur_state)
            ST_SHUT:      out_s = '0;
            ST_OPENING:   out_s.motor_open  = 1'b1;
            ST_OPEN_DONE: out_s.open_done   = 1'b1;
            ST_OPENED:    out_s = '0;
            ST_CLOSING:   out_s.motor_close = 1'b1;
            ST_SHUT_DONE: out_s.close_done  = 1'b1;
            default:      out_s = '0;
        endcase
    end

endmodule

// File: rtl/door_ctl.sv
module door_ctl
    import door_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic open_rq,
    input  logic close_rq,
    input  logic pos_open,
    input  logic pos_shut,
    input  logic obstacle,
    output logic motor_open,
    output logic motor_close,
    output logic open_done,
    output logic close_done
);

    door_state_e state_q;
    door_state_e state_d;
    door_in_t    in_s;
    door_out_t   out_s;

    assign in_s = '{open_rq:  open_rq,
                    close_rq: close_rq,
                    pos_open: pos_open,
                    pos_shut: pos_shut,
                    obstacle: obstacle};

    door_ctl_next u_next (
        .cur_state (state_q),
        .in_s      (in_s),
        .nxt_state (state_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_SHUT;
        else
            state_q <= state_d;
    end

    door_ctl_outdec u_outdec (
        .cur_state (state_q),
        .out_s     (out_s)
    );

    assign motor_open  = out_s.motor_open;
    assign motor_close = out_s.motor_close;
    assign open_done   = out_s.open_done;
    assign close_done  = out_s.close_done;

endmodule

// File: rtl/door_ctl_chk.sv
module door_ctl_chk (
    input logic clk,
    input logic rst_n,
    input logic open_rq,
    input logic close_rq,
    input logic pos_open,
    input logic pos_shut,
    input logic obstacle,
    input logic motor_open,
    input logic motor_close,
    input logic open_done,
    input logic close_done
);

    AST_NO_DUAL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(motor_open && motor_close)); // R8

    AST_ACK_MOTOR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (open_done || close_done) |-> !(motor_open || motor_close)); // R8

    AST_OPEN_DONE_AFTER_POS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(open_done) && $past(motor_open)) |-> $past(pos_open)); // R2

    AST_CLOSE_DONE_AFTER_POS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(close_done) && $past(motor_close)) |-> $past(pos_shut)); // R4

    AST_OBSTACLE_REVERSES: assert property (@(posedge clk) disable iff (!rst_n)
        (motor_close && obstacle) |=> (motor_open && !motor_close)); // R5

    AST_OPEN_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (open_done && open_rq) |=> open_done); // R3

    AST_OPEN_DONE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (open_done && !open_rq) |=> !open_done); // R3

    AST_CLOSE_DONE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (close_done && !close_rq) |=> !close_done); // R4

    AST_OPENING_IGNORES_OBST: assert property (@(posedge clk) disable iff (!rst_n)
        (motor_open && !pos_open) |=> motor_open); // R10

endmodule

bind door_ctl door_ctl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .open_rq     (open_rq),
    .close_rq    (close_rq),
    .pos_open    (pos_open),
    .pos_shut    (pos_shut),
    .obstacle    (obstacle),
    .motor_open  (motor_open),
    .motor_close (motor_close),
    .open_done   (open_done),
    .close_done  (close_done)
);

// File: tb/door_ctl_tb.sv
module door_ctl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NSTEP      = 33;

    // Vector layout: [8:4] = open_rq, close_rq, pos_open, pos_shut, obstacle
    //                [3:0] = expected motor_open, motor_close, open_done, close_done
    localparam logic [8:0] VEC [0:NSTEP-1] = '{
        9'b00010_0000, 9'b10010_1000, 9'b10000_1000, 9'b10100_0010,
        9'b10100_0010, 9'b00100_0000, 9'b01101_0000, 9'b01100_0100,
        9'b01000_0100, 9'b01001_1000, 9'b01001_1000, 9'b01101_0000,
        9'b01101_0000, 9'b01100_0100, 9'b01010_0001, 9'b01010_0001,
        9'b00010_0000, 9'b01010_0001, 9'b00010_0000, 9'b10000_1000,
        9'b10100_0010, 9'b00100_0000, 9'b10100_0010, 9'b00100_0000,
        9'b01000_0100, 9'b11000_1000, 9'b11100_0010, 9'b01100_0000,
        9'b01100_0100, 9'b01010_0001, 9'b11010_0001, 9'b10010_0000,
        9'b10010_1000
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic open_rq = 1'b0, close_rq = 1'b0;
    logic pos_open = 1'b0, pos_shut = 1'b1, obstacle = 1'b0;
    logic motor_open, motor_close, open_done, close_done;
    int   n_chk = 0;
    int   n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    door_ctl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .open_rq     (open_rq),
        .close_rq    (close_rq),
        .pos_open    (pos_open),
        .pos_shut    (pos_shut),
        .obstacle    (obstacle),
        .motor_open  (motor_open),
        .motor_close (motor_close),
        .open_done   (open_done),
        .close_done  (close_done)
    );

    function automatic string tag_of(input int s);
        case (s)
            0:                          return "R1";
            1, 2, 3, 19, 20, 21, 32:    return "R2";
            4, 5, 27:                   return "R3";
            6:                          return "R6";
            9, 11, 12, 13:              return "R5";
            10:                         return "R10";
            17, 18, 22, 23:             return "R7";
            25, 26:                     return "R9";
            default:                    return "R4";
        endcase
    endfunction

    task automatic check4(input string tag, input logic [3:0] exp);
        logic [3:0] got;
        got = {motor_open, motor_close, open_done, close_done};
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: outputs got %b expected %b", tag, got, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        // R1: outputs during reset and right after release
        repeat (2) @(negedge clk);
        check4("R1", 4'b0000);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check4("R1", 4'b0000);

        for (int s = 0; s < NSTEP; s++) begin
            {open_rq, close_rq, pos_open, pos_shut, obstacle} = VEC[s][8:4];
            @(posedge clk); @(negedge clk);
            check4(tag_of(s), VEC[s][3:0]);
            n_chk++;
            if ((motor_open && motor_close) ||
                ((open_done || close_done) && (motor_open || motor_close))) begin
                n_bad++;
                $display("FAIL R8: step %0d got %b%b%b%b expected exclusive",
                         s, motor_open, motor_close, open_done, close_done);
            end
        end

        // R10: long opening stroke with obstacle toggling, motor stays on
        {open_rq, close_rq, pos_open, pos_shut, obstacle} = 5'b10001;
        repeat (4) begin
            @(posedge clk); @(negedge clk);
            obstacle = ~obstacle;
            check4("R10", 4'b1000);
        end

        // R1: asynchronous reset in mid stroke
        rst_n = 1'b0;
        #1;
        check4("R1", 4'b0000);
        {open_rq, close_rq, pos_open, pos_shut, obstacle} = 5'b00010;
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check4("R1", 4'b0000);

        // R9: both requests at rest closed
        {open_rq, close_rq} = 2'b11;
        @(posedge clk); @(negedge clk);
        check4("R9", 4'b1000);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule